// File: doc/BRIEF.md
# AHB-Lite to APB Bridge

This block turns single transfers from an AHB-Lite bus into APB accesses over a 16-bit peripheral address space. Everything runs on one fast clock. The APB side moves forward only in cycles where the `apb_tick` enable is high, so the peripheral bus runs at the fast clock divided by 1, 2, 4 or 8. The clock divider itself lives outside the block. When the bridge accepts an AHB transfer, it records the address, direction, size and protection bits. It waits for the next tick and then performs a setup phase followed by an access phase. It holds `hreadyout` low until the peripheral completes the access. Burst beats are handled as separate single transfers.

Write data passes straight from the AHB data phase to `pwdata` without a register. By default, read data is registered, so `hrdata` is presented in the cycle after the APB access completes. A peripheral error is returned as a two-cycle AHB ERROR response. The `apb_busy` output is low only when nothing is pending or in flight, so surrounding logic may gate the peripheral clock while it is low.

The controller has six states:
- IDLE: ready, accepting transfers.
- PEND: a request has been captured and the bridge waits for a tick.
- SETUP: `psel` is high and `penable` is low.
- ACCESS: `psel` and `penable` are both high.
- ERR1: first cycle of the error response.
- ERR2: second cycle of the error response.

The transitions are:
- IDLE→PEND on accept.
- PEND→SETUP on a tick.
- SETUP→ACCESS on a tick.
- ACCESS→ACCESS while a tick arrives without `pready`.
- ACCESS→IDLE (or →PEND when the unregistered read path accepts a new transfer) on a tick with `pready` and no error.
- ACCESS→ERR1 on a tick with `pready` and `pslverr`.
- ERR1→ERR2 always.
- ERR2→IDLE, or →PEND on accept.

Top module: `ahb_apb_bridge`

## Requirements
- R1: An APB access is a setup cycle (`psel`=1, `penable`=0) followed by access cycles (`psel`=1, `penable`=1). The access phase repeats until `pready`=1 in a cycle with `apb_tick`=1.
- R2: `psel` and `penable` change only after a cycle with `apb_tick`=1. With a tick every N cycles (N = 1, 2, 4 or 8), the setup phase lasts exactly N fast-clock cycles.
- R3: `paddr[15:2]` equals `haddr[15:2]` of the accepted transfer and stays stable while `psel` is high.
- R4: For writes, `pstrb` follows the transfer size and the low address bits:
  - Size 2 (word) gives 4'b1111.
  - Size 1 (halfword) gives 4'b0011 when `haddr[1]`=0 and 4'b1100 when `haddr[1]`=1.
  - Size 0 (byte) with `haddr[1:0]` = 00, 01, 10, 11 gives 4'b0001, 4'b0010, 4'b0100, 4'b1000.
  - Reads give 4'b0000.
- R5: `pprot[0]` = `hprot[1]`, `pprot[1]` = 0 and `pprot[2]` = NOT `hprot[0]`.
- R6: `hreadyout` is low from the cycle after acceptance until the APB access completes. A transfer is accepted when `hsel`=1, `hready`=1, `hreadyout`=1 and `htrans[1]`=1 (NONSEQ 2'b10 or SEQ 2'b11).
- R7: `pslverr`=1 at completion gives `hresp`=1 with `hreadyout`=0 for one cycle, then `hresp`=1 with `hreadyout`=1 for one cycle.
- R8: A completion without `pslverr` ends with `hresp`=0 (OKAY) when `hreadyout` returns high.
- R9: With `REG_RDATA`=1 (default), `hrdata` equals the `prdata` sampled at completion, from the first cycle in which `hreadyout` is high again. With `REG_RDATA`=0, `hrdata` follows `prdata` directly.
- R10: `apb_busy` is high whenever a transfer is pending, in an APB phase or in an error response. While `apb_busy` is low, `hreadyout`=1 and `hresp`=0.
- R11: `pwrite` equals `hwrite` of the accepted transfer, and `pwdata` carries the `hwdata` of that transfer's data phase.
- R12: Cycles with `htrans` IDLE (2'b00) or BUSY (2'b01), with `hsel`=0 or with `hready`=0 start no APB access. `psel` and `apb_busy` stay 0 and `hreadyout` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| apb_tick | input | 1 | Peripheral-side advance enable |
| hsel | input | 1 | AHB slave select |
| haddr | input | 16 | AHB address |
| htrans | input | 2 | AHB transfer type |
| hsize | input | 3 | AHB transfer size |
| hprot | input | 4 | AHB protection |
| hwrite | input | 1 | AHB direction, 1 = write |
| hready | input | 1 | AHB bus ready |
| hwdata | input | 32 | AHB write data |
| hreadyout | output | 1 | Bridge ready |
| hrdata | output | 32 | AHB read data |
| hresp | output | 1 | AHB response, 1 = ERROR |
| paddr | output | 16 | APB address |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| pstrb | output | 4 | APB write strobes |
| pprot | output | 3 | APB protection |
| pwdata | output | 32 | APB write data |
| psel | output | 1 | APB select |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB error |
| apb_busy | output | 1 | Bridge has work pending or in flight |

## Verification
Results arrive on the following schedule:
- Setup: after acceptance, the bridge spends one cycle in PEND plus the wait for the next tick, then sits in setup for exactly one tick period.
- Access: the access phase takes one tick period per `pready`-low repetition plus the completing period.
- Completion: with the default registered read path, `hreadyout` and `hrdata` become valid one cycle after the completing tick edge. An error adds exactly one low-ready cycle before the high-ready ERROR cycle.

The bench drives inputs and samples outputs only at falling edges, with a short settle delay. It captures APB fields in the first setup cycle it sees, counts setup cycles against the programmed tick ratio, and takes the AHB result in the first cycle after the access in which `hreadyout` is high. It never assumes a fixed latency.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_SETUP,
        ST_ACCESS,
        ST_ERR1,
        ST_ERR2
    } brg_state_e;

    localparam int TRANS_ACTIVE_BIT = 1;
    localparam int PROT_W           = 3;
    localparam int HPROT_W          = 4;
    localparam int HSIZE_W          = 3;
    localparam int HTRANS_W         = 2;

endpackage

// File: rtl/bridge_req_capture.sv
module bridge_req_capture
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        take,
    input  logic [ADDR_W-1:0]           haddr,
    input  logic                        hwrite,
    input  logic [HSIZE_W-1:0]          hsize,
    input  logic [HPROT_W-1:0]          hprot,
    output logic [ADDR_W-1:0]           req_addr,
    output logic                        req_write,
    output logic [DATA_W/8-1:0]         req_strb,
    output logic [PROT_W-1:0]           req_prot
);

    localparam int STRB_W = DATA_W / 8;
    localparam int LANE_W = (STRB_W > 1) ? $clog2(STRB_W) : 1;

    function automatic logic [STRB_W-1:0] lane_mask(
        input logic [HSIZE_W-1:0] size,
        input logic [LANE_W-1:0]  lane
    );
        int nb;
        int base;
        logic [STRB_W-1:0] m;
        nb = 1;
        for (int s = 0; s < (1 << HSIZE_W); s++) begin
            if (s < int'(size) && nb < STRB_W) nb = nb * 2;
        end
        base = int'(lane) - (int'(lane) % nb);
        for (int i = 0; i < STRB_W; i++) begin
            m[i] = (i >= base) && (i < base + nb);
        end
        return m;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr  <= '0;
            req_write <= 1'b0;
            req_strb  <= '0;
            req_prot  <= '0;
        end else if (take) begin
            req_addr  <= haddr;
            req_write <= hwrite;
            req_strb  <= hwrite ? lane_mask(hsize, haddr[LANE_W-1:0]) : '0;
            req_prot  <= {~hprot[0], 1'b0, hprot[1]};
        end
    end

endmodule

// File: rtl/bridge_fsm.sv
module bridge_fsm
    import bridge_pkg::*;
#(
    parameter bit REG_RDATA = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic accept,
    input  logic pready,
    input  logic pslverr,
    output logic psel,
    output logic penable,
    output logic hreadyout,
    output logic hresp,
    output logic apb_busy,
    output logic finish
);

    brg_state_e state_q;
    brg_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_PEND;
            ST_PEND:   if (tick) state_d = ST_SETUP;
            ST_SETUP:  if (tick) state_d = ST_ACCESS;
            ST_ACCESS: begin
                if (tick && pready) begin
                    if (pslverr)                  state_d = ST_ERR1;
                    else if (!REG_RDATA && accept) state_d = ST_PEND;
                    else                          state_d = ST_IDLE;
                end
            end
            ST_ERR1:   state_d = ST_ERR2;
            ST_ERR2:   state_d = accept ? ST_PEND : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        psel      = 1'b0;
        penable   = 1'b0;
        hreadyout = 1'b0;
        hresp     = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE:   hreadyout = 1'b1;
            ST_PEND:   ;
            ST_SETUP:  psel = 1'b1;
            ST_ACCESS: begin
                psel      = 1'b1;
                penable   = 1'b1;
                finish    = tick && pready;
                hreadyout = !REG_RDATA && tick && pready && !pslverr;
            end
            ST_ERR1:   hresp = 1'b1;
            ST_ERR2: begin
                hresp     = 1'b1;
                hreadyout = 1'b1;
            end
            default:   hreadyout = 1'b1;
        endcase
        apb_busy = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/bridge_rdata.sv
module bridge_rdata #(
    parameter int DATA_W    = 32,
    parameter bit REG_RDATA = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish,
    input  logic [DATA_W-1:0] prdata,
    output logic [DATA_W-1:0] hrdata
);

    generate
        if (REG_RDATA) begin : g_reg
            logic [DATA_W-1:0] hold_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      hold_q <= '0;
                else if (finish) hold_q <= prdata;
            end
            assign hrdata = hold_q;
        end else begin : g_pass
            assign hrdata = prdata;
        end
    endgenerate

endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter bit REG_RDATA = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   apb_tick,
    input  logic                   hsel,
    input  logic [ADDR_W-1:0]      haddr,
    input  logic [HTRANS_W-1:0]    htrans,
    input  logic [HSIZE_W-1:0]     hsize,
    input  logic [HPROT_W-1:0]     hprot,
    input  logic                   hwrite,
    input  logic                   hready,
    input  logic [DATA_W-1:0]      hwdata,
    output logic                   hreadyout,
    output logic [DATA_W-1:0]      hrdata,
    output logic                   hresp,
    output logic [ADDR_W-1:0]      paddr,
    output logic                   penable,
    output logic                   pwrite,
    output logic [DATA_W/8-1:0]    pstrb,
    output logic [PROT_W-1:0]      pprot,
    output logic [DATA_W-1:0]      pwdata,
    output logic                   psel,
    input  logic [DATA_W-1:0]      prdata,
    input  logic                   pready,
    input  logic                   pslverr,
    output logic                   apb_busy
);

    logic accept;
    logic finish;

    assign accept = hreadyout && hsel && hready && htrans[TRANS_ACTIVE_BIT];
    assign pwdata = hwdata;

    bridge_req_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .haddr     (haddr),
        .hwrite    (hwrite),
        .hsize     (hsize),
        .hprot     (hprot),
        .req_addr  (paddr),
        .req_write (pwrite),
        .req_strb  (pstrb),
        .req_prot  (pprot)
    );

    bridge_fsm #(.REG_RDATA(REG_RDATA)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (apb_tick),
        .accept    (accept),
        .pready    (pready),
        .pslverr   (pslverr),
        .psel      (psel),
        .penable   (penable),
        .hreadyout (hreadyout),
        .hresp     (hresp),
        .apb_busy  (apb_busy),
        .finish    (finish)
    );

    bridge_rdata #(.DATA_W(DATA_W), .REG_RDATA(REG_RDATA)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .finish (finish),
        .prdata (prdata),
        .hrdata (hrdata)
    );

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                apb_tick,
    input logic                hreadyout,
    input logic                hresp,
    input logic [ADDR_W-1:0]   paddr,
    input logic                penable,
    input logic                pwrite,
    input logic [DATA_W/8-1:0] pstrb,
    input logic [2:0]          pprot,
    input logic                psel,
    input logic                pready,
    input logic                pslverr,
    input logic                apb_busy
);

    AST_SETUP_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !penable && apb_tick |=> psel && penable); // R1
    AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel); // R1
    AST_ACCESS_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !(apb_tick && pready) |=> psel && penable); // R1
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !apb_tick |=> $stable(psel) && $stable(penable)); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !(penable && apb_tick && pready) |=> $stable(paddr)); // R3
    AST_READ_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !pwrite |-> pstrb == '0); // R4
    AST_STRB_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        psel && pwrite |-> ($countones(pstrb) == 1 || $countones(pstrb) == 2
                            || $countones(pstrb) == 4)); // R4
    AST_PROT_MID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        psel |-> !pprot[1]); // R5
    AST_STALL_DURING_APB: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !(penable && apb_tick && pready) |-> !hreadyout); // R6
    AST_ERR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && apb_tick && pready && pslverr |=> hresp && !hreadyout); // R7
    AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        hresp && !hreadyout |=> hresp && hreadyout); // R7
    AST_ACTIVE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        psel |-> apb_busy); // R10
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !apb_busy |-> hreadyout && !hresp); // R10

endmodule

bind ahb_apb_bridge bridge_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .apb_tick  (apb_tick),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .paddr     (paddr),
    .penable   (penable),
    .pwrite    (pwrite),
    .pstrb     (pstrb),
    .pprot     (pprot),
    .psel      (psel),
    .pready    (pready),
    .pslverr   (pslverr),
    .apb_busy  (apb_busy)
);

// File: tb/ahb_apb_bridge_test.sv
module ahb_apb_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        apb_tick = 1'b0;
    logic        hsel = 1'b0;
    logic [15:0] haddr = '0;
    logic [1:0]  htrans = '0;
    logic [2:0]  hsize = '0;
    logic [3:0]  hprot = '0;
    logic        hwrite = 1'b0;
    logic        hready = 1'b1;
    logic [31:0] hwdata = '0;
    logic        hreadyout;
    logic [31:0] hrdata;
    logic        hresp;
    logic [15:0] paddr;
    logic        penable;
    logic        pwrite;
    logic [3:0]  pstrb;
    logic [2:0]  pprot;
    logic [31:0] pwdata;
    logic        psel;
    logic [31:0] prdata = '0;
    logic        pready = 1'b0;
    logic        pslverr = 1'b0;
    logic        apb_busy;

    int checks = 0;
    int fails  = 0;
    int ratio  = 1;
    int tcnt   = 0;
    bit finished = 1'b0;

    ahb_apb_bridge uut (
        .clk(clk), .rst_n(rst_n), .apb_tick(apb_tick), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hsize(hsize), .hprot(hprot), .hwrite(hwrite),
        .hready(hready), .hwdata(hwdata), .hreadyout(hreadyout), .hrdata(hrdata),
        .hresp(hresp), .paddr(paddr), .penable(penable), .pwrite(pwrite),
        .pstrb(pstrb), .pprot(pprot), .pwdata(pwdata), .psel(psel),
        .prdata(prdata), .pready(pready), .pslverr(pslverr), .apb_busy(apb_busy)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            if (tcnt >= ratio - 1) tcnt = 0;
            else                   tcnt = tcnt + 1;
            apb_tick = (tcnt == ratio - 1);
        end
    end

    typedef struct packed {
        logic        wr;
        logic [1:0]  size;
        logic [15:0] addr;
        logic [3:0]  prot;
        logic [31:0] data;
        logic        err;
        logic [1:0]  waits;
        logic [3:0]  ratio;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd2, 16'h1234, 4'b0011, 32'hDEADBEEF, 1'b0, 2'd0, 4'd1},
        '{1'b0, 2'd2, 16'h0F08, 4'b0001, 32'h12345678, 1'b0, 2'd0, 4'd2},
        '{1'b1, 2'd1, 16'h0042, 4'b0010, 32'hAAAA5555, 1'b0, 2'd1, 4'd4},
        '{1'b1, 2'd1, 16'h0040, 4'b0000, 32'h0BAD0C0D, 1'b0, 2'd0, 4'd8},
        '{1'b1, 2'd0, 16'h0100, 4'b0001, 32'h00000011, 1'b0, 2'd0, 4'd1},
        '{1'b1, 2'd0, 16'h0101, 4'b0011, 32'h00002200, 1'b0, 2'd0, 4'd2},
        '{1'b1, 2'd0, 16'h0102, 4'b0000, 32'h00330000, 1'b0, 2'd2, 4'd4},
        '{1'b1, 2'd0, 16'hFFFF, 4'b0010, 32'h44000000, 1'b0, 2'd0, 4'd1},
        '{1'b0, 2'd2, 16'h8000, 4'b0001, 32'hCAFEF00D, 1'b1, 2'd1, 4'd2},
        '{1'b1, 2'd2, 16'h0004, 4'b0011, 32'h5A5A5A5A, 1'b1, 2'd0, 4'd8},
        '{1'b0, 2'd1, 16'h00A2, 4'b0001, 32'h0000BEEF, 1'b0, 2'd3, 4'd1}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R4 encodings written out per size and low address bits
    function automatic logic [3:0] exp_strb(input logic wr, input logic [1:0] size,
                                            input logic [1:0] lo);
        if (!wr) return 4'b0000;
        case (size)
            2'd2: return 4'b1111;
            2'd1: return lo[1] ? 4'b1100 : 4'b0011;
            default: case (lo)
                2'b00: return 4'b0001;
                2'b01: return 4'b0010;
                2'b10: return 4'b0100;
                default: return 4'b1000;
            endcase
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        int setup_n = 0;
        int acc_ticks = 0;
        bit acc_seen = 1'b0;
        bit err1 = 1'b0;
        bit done = 1'b0;
        bit busy_seen = 1'b0;
        logic [15:0] s_addr = '0;
        logic        s_wr = 1'b0;
        logic [3:0]  s_strb = '0;
        logic [2:0]  s_prot = '0;
        logic [31:0] s_wdata = '0;
        logic        r_resp = 1'b0;
        logic [31:0] r_data = '0;
        ratio = int'(v.ratio);
        repeat (10) @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; haddr = v.addr; hwrite = v.wr;
        hsize = {1'b0, v.size}; hprot = v.prot; hready = 1'b1;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = v.data;
        for (int i = 0; i < 400 && !done; i++) begin
            #1;
            if (psel && penable) begin
                acc_seen = 1'b1;
                pready   = (acc_ticks >= int'(v.waits));
                pslverr  = pready && v.err;
                prdata   = v.data;
                if (apb_tick) acc_ticks++;
            end else begin
                pready = 1'b0; pslverr = 1'b0;
            end
            if (psel && !penable) begin
                setup_n++;
                if (setup_n == 1) begin
                    s_addr = paddr; s_wr = pwrite; s_strb = pstrb;
                    s_prot = pprot; s_wdata = pwdata; busy_seen = apb_busy;
                end
            end
            #1;
            if (acc_seen && hreadyout) begin
                done = 1'b1; r_resp = hresp; r_data = hrdata;
            end else begin
                if (hresp && !hreadyout) err1 = 1'b1;
                @(negedge clk);
            end
        end
        pready = 1'b0; pslverr = 1'b0;
        check(done, "R6 completion", 32'(done), 1);
        check(setup_n == ratio, "R2 setup length", setup_n, ratio);
        check(acc_ticks == int'(v.waits) + 1, "R1 access periods", acc_ticks, int'(v.waits) + 1);
        check(s_addr[15:2] == v.addr[15:2], "R3 paddr", s_addr, v.addr);
        check(s_wr == v.wr, "R11 pwrite", s_wr, v.wr);
        if (v.wr) check(s_wdata == v.data, "R11 pwdata", s_wdata, v.data);
        check(s_strb == exp_strb(v.wr, v.size, v.addr[1:0]), "R4 pstrb", s_strb,
              exp_strb(v.wr, v.size, v.addr[1:0]));
        check(s_prot == {~v.prot[0], 1'b0, v.prot[1]}, "R5 pprot", s_prot,
              {~v.prot[0], 1'b0, v.prot[1]});
        check(busy_seen, "R10 busy in setup", busy_seen, 1);
        if (v.err) begin
            check(err1 && r_resp, "R7 two-cycle error", {err1, r_resp}, 2'b11);
        end else begin
            check(!err1 && !r_resp, "R8 okay response", {err1, r_resp}, 0);
            if (!v.wr) check(r_data == v.data, "R9 read data", r_data, v.data);
        end
        @(negedge clk); #1;
        check(!apb_busy, "R10 busy cleared", apb_busy, 0);
    endtask

    task automatic ignored(input logic s, input logic r, input logic [1:0] t, input string tag);
        bit bad = 1'b0;
        ratio = 1;
        @(negedge clk);
        hsel = s; hready = r; htrans = t; hwrite = 1'b1; haddr = 16'h0010; hsize = 3'd2;
        @(negedge clk);
        hsel = 1'b0; hready = 1'b1; htrans = 2'b00;
        repeat (12) begin
            #1;
            if (psel || apb_busy || !hreadyout) bad = 1'b1;
            @(negedge clk);
        end
        check(!bad, tag, bad, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(hreadyout && !hresp && !psel && !penable && !apb_busy, "R10 reset state",
              {hreadyout, hresp, psel, penable, apb_busy}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(hreadyout && !psel && !apb_busy, "R10 after reset",
              {hreadyout, psel, apb_busy}, 3'b101);
        for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);
        ignored(1'b1, 1'b1, 2'b00, "R12 idle htrans");
        ignored(1'b1, 1'b1, 2'b01, "R12 busy htrans");
        ignored(1'b0, 1'b1, 2'b10, "R12 hsel low");
        ignored(1'b1, 1'b0, 2'b10, "R12 hready low");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule